// File: doc/BRIEF.md
# Biphase Stream Copy-Bit Rewriter

This block sits on a serial S/PDIF line that has already been sampled at twice the bit rate, so that each clock delivers one half-cell of the biphase-mark code. It re-emits that stream one clock later, unchanged, except in the third frame of every channel-status block. There the consumer copy flag (subframe bit 30) is forced to the "copying permitted" value, and the parity bit that follows it is inverted so that the subframe stays consistent.

The stream is never decoded into words. A short history of half-cells is matched against the block-start (Z) and left-channel (X) preamble patterns, and a position counter started by the Z preamble finds the channel-status cells. A 0 in biphase-mark has two equal half-cells and a 1 has two unequal ones. The rewrite therefore only touches the second half-cell of the copy bit and the first half-cell of the parity bit. Every other half-cell, including the line level at the end of the subframe, comes out as it went in.

Top module: `copy_bit_rewriter`

## Requirements
- R1: A synchronous reset clears the half-cell history, returns the machine to the hunt state and drives `dout` low. A reset partway through a block cancels any pending rewrite in that block.
- R2: Apart from the half-cells named in R6, `dout` in the cycle after a rising clock edge equals the `din` value sampled at that edge, which gives a fixed latency of one clock.
- R3: Tracking starts when the current sample and the seven before it read 11101000, oldest sample first and the current sample last. Until that happens, nothing in the stream is modified.
- R4: Half-cell 7 of the fifth subframe after the Z preamble, counting from subframe 0, half-cell 0, must complete the pattern 11100010, oldest first. If it does not, tracking is abandoned and nothing is modified until the next Z preamble.
- R5: In each subframe of frame 2 the copy bit occupies half-cells 60 and 61, and the parity bit occupies half-cells 62 and 63. If the copy bit is 1 (its two half-cells differ), all four half-cells pass through unchanged.
- R6: If the copy bit is 0 (its two half-cells are equal), half-cells 61 and 62 are emitted inverted while 60 and 63 are left as they are. The output then carries a copy bit of 1 that starts with a transition, and an inverted parity bit, whatever the received parity was.
- R7: Both subframes of frame 2 are judged and rewritten independently of each other.
- R8: Channel-status bits in frames other than frame 2 are never changed, and the line level at the end of every subframe is the same on `dout` as on `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cell rate clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Sampled half-cell of the incoming biphase-mark line |
| dout | output | 1 | Registered half-cell of the outgoing line |

## Verification
The copy-bit judgement and the parity inversion share one cycle. At half-cell 62 the block emits the inverted parity cell while deciding, from older history entries, whether the copy bit was 0. A single misplaced history tap would therefore hit either the copy or the parity cell. The bench provokes this with copy bits of both values, carried in subframes whose random audio data gives both parity values. It judges every output half-cell against a stream that the bench re-encodes independently from the intended bit values.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic {
    MODE_HUNT  = 1'b0,
    MODE_TRACK = 1'b1
  } mode_t;

  // Half-cell index, counted from the first preamble half-cell after the
  // block-start marker, of the first half-cell of a given bit in a given subframe.
  function automatic int bit_cell(input int sf_idx, input int sf_hc, input int bit_idx);
    return sf_idx * sf_hc + 2 * bit_idx;
  endfunction

  // Biphase-mark zero: both half-cells of the bit at the same level.
  function automatic logic bm_is_zero(input logic first_half, input logic second_half);
    return first_half == second_half;
  endfunction

endpackage

// File: rtl/cbr_window.sv
module cbr_window #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [WIN_W-1:0] win_now
);
  logic [WIN_W-2:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= win_now[WIN_W-2:0];
  end

  assign win_now = {hist_q, din};
endmodule

// File: rtl/cbr_match.sv
module cbr_match #(
  parameter int             WIN_W = 8,
  parameter logic [WIN_W-1:0] PAT = '0
) (
  input  logic [WIN_W-1:0] win,
  output logic             hit
);
  assign hit = (win == PAT);
endmodule

// File: rtl/cbr_seq.sv
module cbr_seq #(
  parameter int CW        = 9,
  parameter int START_POS = 8,
  parameter int X_POS     = 263,
  parameter int LAST_POS  = 383
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          z_hit,
  input  logic          x_hit,
  output logic          tracking,
  output logic          x_check,
  output logic [CW-1:0] cnt
);
  import cbr_pkg::*;

  localparam logic [CW-1:0] START_CNT = CW'(START_POS);
  localparam logic [CW-1:0] X_CNT     = CW'(X_POS);
  localparam logic [CW-1:0] LAST_CNT  = CW'(LAST_POS);

  mode_t         mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign x_check  = (mode_q == MODE_TRACK) && (cnt_q == X_CNT);
  assign tracking = (mode_q == MODE_TRACK);
  assign cnt      = cnt_q;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (mode_q == MODE_HUNT) begin
      if (z_hit) begin
        mode_d = MODE_TRACK;
        cnt_d  = START_CNT;
      end
    end else if (cnt_q == LAST_CNT || (x_check && !x_hit)) begin
      mode_d = MODE_HUNT;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_HUNT;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/cbr_edit.sv
module cbr_edit #(
  parameter int CW       = 9,
  parameter int FIRST_SF = 4,
  parameter int N_SUB    = 2,
  parameter int SF_HC    = 64,
  parameter int COPY_BIT = 30
) (
  input  logic          tracking,
  input  logic [CW-1:0] cnt,
  input  logic [2:0]    recent,
  output logic          flip
);
  import cbr_pkg::*;

  logic [N_SUB-1:0] hit;

  for (genvar s = 0; s < N_SUB; s++) begin : g_sf
    localparam int            CELL0 = bit_cell(FIRST_SF + s, SF_HC, COPY_BIT);
    localparam logic [CW-1:0] C_2ND = CW'(CELL0 + 1);
    localparam logic [CW-1:0] P_1ST = CW'(CELL0 + 2);
    // Second copy half-cell: judge on the pair now in the window.
    // First parity half-cell: the copy pair has moved one place older.
    assign hit[s] = ((cnt == C_2ND) && bm_is_zero(recent[1], recent[0])) ||
                    ((cnt == P_1ST) && bm_is_zero(recent[2], recent[1]));
  end

  assign flip = tracking && (|hit);
endmodule

// File: rtl/copy_bit_rewriter.sv
module copy_bit_rewriter #(
  parameter int          SF_BITS    = 32,
  parameter int          COPY_BIT   = 30,
  parameter int          EDIT_FRAME = 2,
  parameter int          SF_PER_FR  = 2,
  parameter int          WIN_W      = 8,
  parameter logic [7:0]  PRE_Z      = 8'b11101000,
  parameter logic [7:0]  PRE_X      = 8'b11100010
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int SF_HC    = 2 * SF_BITS;
  localparam int FIRST_SF = EDIT_FRAME * SF_PER_FR;
  localparam int MARK_POS = WIN_W - 1;
  localparam int X_POS    = FIRST_SF * SF_HC + MARK_POS;
  localparam int LAST_POS = (FIRST_SF + SF_PER_FR) * SF_HC - 1;
  localparam int CW       = $clog2(LAST_POS + 1);

  logic [WIN_W-1:0] win_now;
  logic             z_hit, x_hit, x_check, tracking, flip;
  logic [CW-1:0]    cnt;
  logic             dout_q;

  cbr_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .din(din), .win_now(win_now)
  );

  cbr_match #(.WIN_W(WIN_W), .PAT(PRE_Z)) u_zmatch (.win(win_now), .hit(z_hit));
  cbr_match #(.WIN_W(WIN_W), .PAT(PRE_X)) u_xmatch (.win(win_now), .hit(x_hit));

  cbr_seq #(
    .CW(CW), .START_POS(MARK_POS + 1), .X_POS(X_POS), .LAST_POS(LAST_POS)
  ) u_seq (
    .clk(clk), .rst(rst), .z_hit(z_hit), .x_hit(x_hit),
    .tracking(tracking), .x_check(x_check), .cnt(cnt)
  );

  cbr_edit #(
    .CW(CW), .FIRST_SF(FIRST_SF), .N_SUB(SF_PER_FR), .SF_HC(SF_HC), .COPY_BIT(COPY_BIT)
  ) u_edit (
    .tracking(tracking), .cnt(cnt), .recent(win_now[2:0]), .flip(flip)
  );

  always_ff @(posedge clk) begin
    if (rst) dout_q <= 1'b0;
    else     dout_q <= din ^ flip;
  end

  assign dout = dout_q;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker (
  input logic clk,
  input logic rst,
  input logic din,
  input logic dout,
  input logic z_hit,
  input logic x_hit,
  input logic x_check,
  input logic tracking,
  input logic flip
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!dout && !tracking));

  p_pass_latency_r2: assert property (@(posedge clk) disable iff (rst)
    !flip |=> (dout == $past(din)));

  p_hunt_no_edit_r3: assert property (@(posedge clk) disable iff (rst)
    !tracking |-> !flip);

  p_z_starts_r3: assert property (@(posedge clk) disable iff (rst)
    (!tracking && z_hit) |=> tracking);

  p_x_miss_abort_r4: assert property (@(posedge clk) disable iff (rst)
    (x_check && !x_hit) |=> !tracking);

  p_edit_inverts_r6: assert property (@(posedge clk) disable iff (rst)
    flip |=> (dout != $past(din)));

  p_edit_pair_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flip) |=> flip);

  p_edit_two_cells_r8: assert property (@(posedge clk) disable iff (rst)
    (flip && $past(flip)) |=> !flip);
endmodule

bind copy_bit_rewriter cbr_checker u_chk (
  .clk(clk), .rst(rst), .din(din), .dout(dout),
  .z_hit(z_hit), .x_hit(x_hit), .x_check(x_check),
  .tracking(tracking), .flip(flip)
);

// File: tb/sim_copy_bit_rewriter.sv
`timescale 1ns/1ps
module sim_copy_bit_rewriter;
  localparam int         FRAMES = 8;
  localparam logic [7:0] PZ = 8'b11101000;
  localparam logic [7:0] PX = 8'b11100010;
  localparam logic [7:0] PY = 8'b11100100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout;

  int checks = 0;
  int errors = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  copy_bit_rewriter u0 (.clk(clk), .rst(rst), .din(din), .dout(dout));

  task automatic check(input bit act, input bit expv, input string tag, input string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Compare the pending sample (if any) at a negative edge.
  task automatic settle();
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(dout, e, t, "half-cell");
    end
  endtask

  task automatic step(input bit v, input bit e, input string tag);
    @(negedge clk);
    settle();
    din = v;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // One subframe: random audio, given channel-status bit, even parity.
  // 'edit' means the bench intends the copy bit to be rewritten.
  task automatic send_sf(input logic [7:0] pre, input bit cs, input bit edit,
                         input string cs_tag);
    bit ib[32];
    bit ob[32];
    bit li, lo, par;
    for (int k = 4; k < 30; k++) ib[k] = bit'($urandom_range(0, 1));
    ib[30] = cs;
    par = 1'b0;
    for (int k = 4; k < 31; k++) par ^= ib[k];
    ib[31] = par;
    for (int k = 4; k < 32; k++) ob[k] = ib[k];
    if (edit && !cs) begin
      ob[30] = 1'b1;
      ob[31] = ~par;
    end
    for (int k = 7; k >= 0; k--) step(pre[k], pre[k], "R2");
    li = pre[0];
    lo = pre[0];
    for (int k = 4; k < 32; k++) begin
      bit i0, i1, o0, o1;
      string t;
      li = ~li; i0 = li; if (ib[k]) li = ~li; i1 = li;
      lo = ~lo; o0 = lo; if (ob[k]) lo = ~lo; o1 = lo;
      t = (k >= 30) ? cs_tag : "R2";
      step(i0, o0, t);
      step(i1, o1, t);
    end
  endtask

  task automatic send_block(input int f_first, input int f_last, input bit active,
                            input bit cs0, input bit cs1, input bit bad_x,
                            input string tag0, input string tag1);
    for (int f = f_first; f <= f_last; f++) begin
      for (int s = 0; s < 2; s++) begin
        logic [7:0] pre;
        bit cs;
        string t;
        pre = (f == 0 && s == 0) ? PZ : (s == 0 ? PX : PY);
        if (f == 2 && s == 0 && bad_x) pre = PY;
        cs = (f == 2) ? (s == 0 ? cs0 : cs1) : 1'b0;  // R8: cs=0 outside frame 2
        t  = (f == 2) ? (s == 0 ? tag0 : tag1) : "R8";
        send_sf(pre, cs, active && (f == 2), t);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    settle();
    rst = 1'b1;
    din = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(dout, 1'b0, "R1", "dout during reset");
    end
    exp_q.delete();
    tag_q.delete();
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(dout, 1'b0, "R1", "dout after power-up reset");
    rst = 1'b0;
    for (int i = 0; i < 16; i++) step(1'b0, 1'b0, "R2");
    // R3: join mid-block, frame 2 copy 0, no Z seen yet -> untouched
    send_block(1, FRAMES - 1, 1'b0, 1'b0, 1'b0, 1'b0, "R3", "R3");
    // R6 R7: both subframes copy 0
    send_block(0, FRAMES - 1, 1'b1, 1'b0, 1'b0, 1'b0, "R6", "R7");
    // R5 R7: left copy 1, right copy 0
    send_block(0, FRAMES - 1, 1'b1, 1'b1, 1'b0, 1'b0, "R5", "R7");
    // R4: X replaced by Y at frame 2 -> no edit
    send_block(0, FRAMES - 1, 1'b0, 1'b0, 1'b0, 1'b1, "R4", "R4");
    // R4: recovery on the next Z
    send_block(0, FRAMES - 1, 1'b1, 1'b0, 1'b0, 1'b0, "R4", "R4");
    // R5: both copy 1
    send_block(0, FRAMES - 1, 1'b1, 1'b1, 1'b1, 1'b0, "R5", "R5");
    // R1: reset after frame 1 cancels the rewrite in frame 2
    send_block(0, 1, 1'b0, 1'b0, 1'b0, 1'b0, "R1", "R1");
    do_reset();
    send_block(2, FRAMES - 1, 1'b0, 1'b0, 1'b0, 1'b0, "R1", "R1");
    // R6: normal operation again
    send_block(0, FRAMES - 1, 1'b1, 1'b0, 1'b0, 1'b0, "R6", "R6");
    @(negedge clk);
    settle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule